// File: doc/BRIEF.md
# SMBus Block-Transfer Host Engine

This block is the host side of an SMBus controller, reduced to the block-read and block-write protocols. A processor programs it through a byte-wide register port: it sets the target's 7-bit address and the direction bit, a command code, and a byte count. It fills or drains a 32-entry byte buffer through one data port whose index advances on every access, and it starts the transfer by writing the control register. Status bits report busy, successful completion, a device error and a forced abort. Software clears them by writing ones back.

Toward the wire, the engine does not toggle clock or data lines. It issues byte-level link operations (start condition, send a byte, receive a byte, stop condition) one at a time over a request/done handshake. A separate bit-level engine carries these out and returns the ack/nack of each sent byte and the value of each received byte. The sequencer checks the byte count, turns a nack into a device error, and honours an abort request after the link operation in flight has finished.

Top module: `smbh_host`

## Requirements
- R1: After reset every register reads 0x00, status is idle and no link operation is requested.
- R2: Registers are at fixed offsets: status 0x0, control 0x2, command 0x3, target address 0x4, count/data-0 0x5, data-1 0x6, buffer port 0x7, auxiliary 0xD. Each one reads back what was written. Only bits 1:0 of auxiliary are kept. The start bit (control bit 6) always reads 0. Unmapped offsets read 0x00. Read data appears on `reg_rdata` one clock after `reg_rd`.
- R3: A block write is started by writing control with bit 6 set and bits 4:2 = 5, with address bit 0 = 0. It issues these link operations in order: START, SEND {addr,0}, SEND command, SEND count, SEND each buffered byte, STOP. Link op codes are 0 START, 1 SEND, 2 RECV, 3 STOP.
- R4: A block read (address bit 0 = 1) issues START, SEND {addr,0}, SEND command, START, SEND {addr,1}, RECV count, RECV each data byte, STOP. `lk_last` is high only on the final data RECV. The returned count is placed in data-0 and the bytes are read back in order through the buffer port.
- R5: Successful completion sets status bit 1 and clears status bit 0 (busy).
- R6: Writing a one to status bit 1, 2 or 4 clears that bit. Bits written as zero are left alone.
- R7: Any read of the control register resets the buffer index to entry 0.
- R8: A block write whose count is 0 or above 32 sets status bit 2 (device error), requests no link operation and never sets busy.
- R9: A block read that returns a count of 0 or above 32 sets device error and issues STOP right after the count, with no data RECV.
- R10: A nack on any sent byte sets device error, issues STOP next and leaves status bit 1 clear.
- R11: Writing control bit 1 (kill) during a transfer issues STOP once the current link operation finishes. Busy then clears and status bit 4 (failed) is set, with no completion bit.
- R12: A start request whose control bits 4:2 are not 5 is ignored: no link operation and no status change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 4 | Register offset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, valid the cycle after `reg_rd` |
| lk_req | output | 1 | One-cycle request for a link operation |
| lk_op | output | 2 | Link operation code (0 START, 1 SEND, 2 RECV, 3 STOP) |
| lk_wbyte | output | 8 | Byte to send for SEND |
| lk_last | output | 1 | For RECV: final byte, master answers with nack |
| lk_done | input | 1 | Link operation finished (one cycle) |
| lk_nack | input | 1 | Target did not acknowledge the sent byte (valid with `lk_done`) |
| lk_rbyte | input | 8 | Received byte (valid with `lk_done`) |

## Verification
Every cycle, the assertions check the link request discipline: a request lasts one cycle, none is made while idle, and the last-byte flag only accompanies a receive. They also check that completion and failure bits only rise once busy has dropped, that write-one-to-clear removes the completion bit, that a control read zeroes the buffer index, and that a bad write count never starts the sequencer. The bench scenarios are needed for the exact order and content of link operations in both directions. They also cover the returned count and buffered bytes, and the error paths on a nack, an oversized returned count and an abort in mid-transfer. The register readback rules are covered the same way.

// File: rtl/smbh_pkg.sv
package smbh_pkg;

  localparam logic [3:0] OFF_STAT = 4'h0;
  localparam logic [3:0] OFF_CTRL = 4'h2;
  localparam logic [3:0] OFF_CMD  = 4'h3;
  localparam logic [3:0] OFF_TADR = 4'h4;
  localparam logic [3:0] OFF_DAT0 = 4'h5;
  localparam logic [3:0] OFF_DAT1 = 4'h6;
  localparam logic [3:0] OFF_BLK  = 4'h7;
  localparam logic [3:0] OFF_AUX  = 4'hD;

  localparam int ST_BUSY = 0;
  localparam int ST_DONE = 1;
  localparam int ST_DEV  = 2;
  localparam int ST_FAIL = 4;

  localparam int CT_IEN   = 0;
  localparam int CT_KILL  = 1;
  localparam int CT_LAST  = 5;
  localparam int CT_START = 6;
  localparam int CT_PEC   = 7;
  localparam logic [2:0] PROTO_BLOCK = 3'd5;

  typedef enum logic [1:0] {
    LK_START = 2'd0,
    LK_SEND  = 2'd1,
    LK_RECV  = 2'd2,
    LK_STOP  = 2'd3
  } link_op_t;

  typedef enum logic [1:0] {
    FIN_OK   = 2'd0,
    FIN_DEV  = 2'd1,
    FIN_KILL = 2'd2
  } fin_t;

endpackage

// File: rtl/smbh_buf.sv
module smbh_buf #(
  parameter int DEPTH = 32,
  parameter int WIDTH = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [IDX_W-1:0] raddr,
  output logic [WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/smbh_seq.sv
module smbh_seq
  import smbh_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             rd_req,
  input  logic [6:0]       tgt_addr,
  input  logic [7:0]       cmd,
  input  logic [7:0]       wcount,
  input  logic             kill,
  output logic             busy,
  output logic             fin,
  output fin_t             fin_code,
  output logic             rcount_we,
  output logic [7:0]       rcount,
  output logic [IDX_W-1:0] bidx,
  output logic             bwe,
  output logic [7:0]       bwdata,
  input  logic [7:0]       brdata,
  output logic             lk_req,
  output logic [1:0]       lk_op,
  output logic [7:0]       lk_wbyte,
  output logic             lk_last,
  input  logic             lk_done,
  input  logic             lk_nack,
  input  logic [7:0]       lk_rbyte
);

  typedef enum logic [3:0] {
    S_IDLE, S_ST1, S_AW, S_CMD, S_WCNT, S_WDAT,
    S_ST2, S_AR, S_RCNT, S_RDAT, S_STOP
  } st_t;

  st_t              st;
  logic             waiting;
  logic [7:0]       cnt;
  logic [IDX_W-1:0] idx;
  fin_t             err;
  logic             kill_pend;

  link_op_t op_n;
  logic [7:0] byte_n;
  logic last_n;
  logic at_last;
  logic send_state;

  function automatic logic bad_count(input logic [7:0] c);
    return (c == 8'd0) || (c > 8'(DEPTH));
  endfunction

  assign at_last    = (8'(idx) + 8'd1) == cnt;
  assign send_state = (st == S_AW) || (st == S_CMD) || (st == S_WCNT) ||
                      (st == S_WDAT) || (st == S_AR);

  always_comb begin
    op_n   = LK_SEND;
    byte_n = 8'h00;
    last_n = 1'b0;
    case (st)
      S_ST1, S_ST2: op_n = LK_START;
      S_AW:   byte_n = {tgt_addr, 1'b0};
      S_AR:   byte_n = {tgt_addr, 1'b1};
      S_CMD:  byte_n = cmd;
      S_WCNT: byte_n = cnt;
      S_WDAT: byte_n = brdata;
      S_RCNT: op_n = LK_RECV;
      S_RDAT: begin op_n = LK_RECV; last_n = at_last; end
      S_STOP: op_n = LK_STOP;
      default: ;
    endcase
  end

  assign busy   = (st != S_IDLE);
  assign rcount = cnt;
  assign bidx   = idx;
  assign bwe    = waiting && lk_done && (st == S_RDAT);
  assign bwdata = lk_rbyte;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      waiting   <= 1'b0;
      cnt       <= 8'h00;
      idx       <= '0;
      err       <= FIN_OK;
      kill_pend <= 1'b0;
      fin       <= 1'b0;
      fin_code  <= FIN_OK;
      rcount_we <= 1'b0;
      lk_req    <= 1'b0;
      lk_op     <= 2'd0;
      lk_wbyte  <= 8'h00;
      lk_last   <= 1'b0;
    end else begin
      lk_req    <= 1'b0;
      fin       <= 1'b0;
      rcount_we <= 1'b0;
      if (kill && st != S_IDLE) kill_pend <= 1'b1;
      if (st == S_IDLE) begin
        if (start) begin
          if (!rd_req && bad_count(wcount)) begin
            fin      <= 1'b1;
            fin_code <= FIN_DEV;
          end else begin
            st        <= S_ST1;
            cnt       <= wcount;
            idx       <= '0;
            err       <= FIN_OK;
            kill_pend <= 1'b0;
            waiting   <= 1'b0;
          end
        end
      end else if (!waiting) begin
        lk_req   <= 1'b1;
        lk_op    <= op_n;
        lk_wbyte <= byte_n;
        lk_last  <= last_n;
        waiting  <= 1'b1;
      end else if (lk_done) begin
        waiting <= 1'b0;
        if (st == S_STOP) begin
          st       <= S_IDLE;
          fin      <= 1'b1;
          fin_code <= err;
        end else if (kill_pend || kill) begin
          err <= FIN_KILL;
          st  <= S_STOP;
        end else if (send_state && lk_nack) begin
          err <= FIN_DEV;
          st  <= S_STOP;
        end else begin
          case (st)
            S_ST1:  st <= S_AW;
            S_AW:   st <= S_CMD;
            S_CMD:  st <= rd_req_q ? S_ST2 : S_WCNT;
            S_WCNT: begin st <= S_WDAT; idx <= '0; end
            S_WDAT: begin
              if (at_last) st <= S_STOP;
              else idx <= idx + 1'b1;
            end
            S_ST2:  st <= S_AR;
            S_AR:   st <= S_RCNT;
            S_RCNT: begin
              cnt       <= lk_rbyte;
              rcount_we <= 1'b1;
              idx       <= '0;
              if (bad_count(lk_rbyte)) begin
                err <= FIN_DEV;
                st  <= S_STOP;
              end else begin
                st <= S_RDAT;
              end
            end
            S_RDAT: begin
              if (at_last) st <= S_STOP;
              else idx <= idx + 1'b1;
            end
            default: st <= S_IDLE;
          endcase
        end
      end
    end
  end

  logic rd_req_q;
  always_ff @(posedge clk) begin
    if (rst) rd_req_q <= 1'b0;
    else if (st == S_IDLE && start) rd_req_q <= rd_req;
  end

  a_r3_req_pulse: assert property (@(posedge clk) disable iff (rst)
    lk_req |=> !lk_req);
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !lk_req);
  a_r4_last_on_recv: assert property (@(posedge clk) disable iff (rst)
    (lk_req && lk_last) |-> (lk_op == LK_RECV));
  a_r8_bad_count_idle: assert property (@(posedge clk) disable iff (rst)
    (!busy && start && !rd_req && (wcount == 8'd0 || wcount > 8'(DEPTH)))
      |=> !busy);

endmodule

// File: rtl/smbh_host.sv
module smbh_host
  import smbh_pkg::*;
#(
  parameter int BUF_DEPTH = 32,
  parameter int AW = 4,
  localparam int IDX_W = $clog2(BUF_DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] reg_addr,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  output logic          lk_req,
  output logic [1:0]    lk_op,
  output logic [7:0]    lk_wbyte,
  output logic          lk_last,
  input  logic          lk_done,
  input  logic          lk_nack,
  input  logic [7:0]    lk_rbyte
);

  logic       c_ien, c_kill, c_last, c_pec;
  logic [2:0] c_proto;
  logic [7:0] cmd_q, tadr_q, dat0_q, dat1_q;
  logic       aux_crc, aux_e32;
  logic       s_done, s_dev, s_fail;
  logic [IDX_W-1:0] cpu_idx;

  logic       busy, fin, rcount_we, seq_bwe;
  fin_t       fin_code;
  logic [7:0] rcount, seq_bwdata, buf_rdata;
  logic [IDX_W-1:0] seq_idx;

  logic wr_stat, wr_ctrl, rd_ctrl, blk_wr, blk_rd, start_go, kill_go;

  assign wr_stat  = reg_wr && reg_addr == AW'(OFF_STAT);
  assign wr_ctrl  = reg_wr && reg_addr == AW'(OFF_CTRL);
  assign rd_ctrl  = reg_rd && reg_addr == AW'(OFF_CTRL);
  assign blk_wr   = reg_wr && reg_addr == AW'(OFF_BLK) && !busy;
  assign blk_rd   = reg_rd && reg_addr == AW'(OFF_BLK) && !busy;
  assign start_go = wr_ctrl && reg_wdata[CT_START] &&
                    reg_wdata[4:2] == PROTO_BLOCK && !busy;
  assign kill_go  = wr_ctrl && reg_wdata[CT_KILL];

  smbh_buf #(.DEPTH(BUF_DEPTH), .WIDTH(8)) u_buf (
    .clk   (clk),
    .we    (busy ? seq_bwe : blk_wr),
    .waddr (busy ? seq_idx : cpu_idx),
    .wdata (busy ? seq_bwdata : reg_wdata),
    .raddr (busy ? seq_idx : cpu_idx),
    .rdata (buf_rdata)
  );

  smbh_seq #(.DEPTH(BUF_DEPTH)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .start     (start_go),
    .rd_req    (tadr_q[0]),
    .tgt_addr  (tadr_q[7:1]),
    .cmd       (cmd_q),
    .wcount    (dat0_q),
    .kill      (kill_go),
    .busy      (busy),
    .fin       (fin),
    .fin_code  (fin_code),
    .rcount_we (rcount_we),
    .rcount    (rcount),
    .bidx      (seq_idx),
    .bwe       (seq_bwe),
    .bwdata    (seq_bwdata),
    .brdata    (buf_rdata),
    .lk_req    (lk_req),
    .lk_op     (lk_op),
    .lk_wbyte  (lk_wbyte),
    .lk_last   (lk_last),
    .lk_done   (lk_done),
    .lk_nack   (lk_nack),
    .lk_rbyte  (lk_rbyte)
  );

  // Configuration registers
  always_ff @(posedge clk) begin
    if (rst) begin
      {c_ien, c_kill, c_last, c_pec} <= 4'b0;
      c_proto <= 3'd0;
      cmd_q   <= 8'h00;
      tadr_q  <= 8'h00;
      dat0_q  <= 8'h00;
      dat1_q  <= 8'h00;
      aux_crc <= 1'b0;
      aux_e32 <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        c_ien   <= reg_wdata[CT_IEN];
        c_kill  <= reg_wdata[CT_KILL];
        c_last  <= reg_wdata[CT_LAST];
        c_pec   <= reg_wdata[CT_PEC];
        c_proto <= reg_wdata[4:2];
      end
      if (reg_wr && reg_addr == AW'(OFF_CMD))  cmd_q  <= reg_wdata;
      if (reg_wr && reg_addr == AW'(OFF_TADR)) tadr_q <= reg_wdata;
      if (reg_wr && reg_addr == AW'(OFF_DAT1)) dat1_q <= reg_wdata;
      if (reg_wr && reg_addr == AW'(OFF_AUX)) begin
        aux_crc <= reg_wdata[0];
        aux_e32 <= reg_wdata[1];
      end
      if (rcount_we) dat0_q <= rcount;
      else if (reg_wr && reg_addr == AW'(OFF_DAT0)) dat0_q <= reg_wdata;
    end
  end

  // Status: set by sequencer outcome, write-one-to-clear, set wins
  always_ff @(posedge clk) begin
    if (rst) begin
      s_done <= 1'b0;
      s_dev  <= 1'b0;
      s_fail <= 1'b0;
    end else begin
      if (wr_stat && reg_wdata[ST_DONE]) s_done <= 1'b0;
      if (wr_stat && reg_wdata[ST_DEV])  s_dev  <= 1'b0;
      if (wr_stat && reg_wdata[ST_FAIL]) s_fail <= 1'b0;
      if (fin) begin
        case (fin_code)
          FIN_OK:   s_done <= 1'b1;
          FIN_DEV:  s_dev  <= 1'b1;
          FIN_KILL: s_fail <= 1'b1;
          default:  ;
        endcase
      end
    end
  end

  // Buffer index: auto-increment on port access, zeroed by control read
  always_ff @(posedge clk) begin
    if (rst) cpu_idx <= '0;
    else if (rd_ctrl) cpu_idx <= '0;
    else if (blk_wr || blk_rd) cpu_idx <= cpu_idx + 1'b1;
  end

  // Registered read path
  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= 8'h00;
    end else if (reg_rd) begin
      case (reg_addr)
        AW'(OFF_STAT): reg_rdata <= {3'b000, s_fail, 1'b0, s_dev, s_done, busy};
        AW'(OFF_CTRL): reg_rdata <= {c_pec, 1'b0, c_last, c_proto, c_kill, c_ien};
        AW'(OFF_CMD):  reg_rdata <= cmd_q;
        AW'(OFF_TADR): reg_rdata <= tadr_q;
        AW'(OFF_DAT0): reg_rdata <= dat0_q;
        AW'(OFF_DAT1): reg_rdata <= dat1_q;
        AW'(OFF_BLK):  reg_rdata <= buf_rdata;
        AW'(OFF_AUX):  reg_rdata <= {6'b0, aux_e32, aux_crc};
        default:       reg_rdata <= 8'h00;
      endcase
    end
  end

  a_r5_done_when_idle: assert property (@(posedge clk) disable iff (rst)
    $rose(s_done) |-> !busy);
  a_r11_fail_when_idle: assert property (@(posedge clk) disable iff (rst)
    $rose(s_fail) |-> !busy);
  a_r6_w1c_done: assert property (@(posedge clk) disable iff (rst)
    (wr_stat && reg_wdata[ST_DONE] && !(fin && fin_code == FIN_OK)) |=> !s_done);
  a_r7_idx_zeroed: assert property (@(posedge clk) disable iff (rst)
    rd_ctrl |=> cpu_idx == '0);

endmodule

// File: tb/smbh_host_test.sv
module smbh_host_test;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst;
  logic [3:0] reg_addr;
  logic       reg_wr, reg_rd;
  logic [7:0] reg_wdata, reg_rdata;
  logic       lk_req, lk_last, lk_done, lk_nack;
  logic [1:0] lk_op;
  logic [7:0] lk_wbyte, lk_rbyte;

  always #(CLK_PERIOD/2) clk = ~clk;

  smbh_host uut (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lk_req(lk_req), .lk_op(lk_op),
    .lk_wbyte(lk_wbyte), .lk_last(lk_last), .lk_done(lk_done), .lk_nack(lk_nack),
    .lk_rbyte(lk_rbyte)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  // link model state
  int nlog, nack_at, lk_delay, rxi;
  logic [7:0] rxq [64];
  logic [1:0] log_op [64];
  logic [7:0] log_byte [64];
  logic       log_last [64];

  // offset, write value, expected readback
  localparam logic [23:0] TBL [9] = '{
    {8'h03, 8'h5A, 8'h5A},
    {8'h04, 8'hA1, 8'hA1},
    {8'h05, 8'h07, 8'h07},
    {8'h06, 8'hC3, 8'hC3},
    {8'h0D, 8'h03, 8'h03},
    {8'h0D, 8'hFE, 8'h02},
    {8'h02, 8'h81, 8'h81},
    {8'h02, 8'h60, 8'h20},
    {8'h08, 8'hFF, 8'h00}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [7:0] s;
    for (int i = 0; i < 2000; i++) begin
      reg_read(4'h0, s);
      if (!s[0]) break;
    end
  endtask

  task automatic clear_all();
    reg_write(4'h0, 8'hFF);
    nlog = 0; rxi = 0; nack_at = -1;
  endtask

  task automatic log_is(input string req, input int i, input logic [1:0] op, input logic [7:0] b);
    chk(req, {22'd0, log_op[i], log_byte[i]}, {22'd0, op, (op == 2'd1) ? b : log_byte[i]});
  endtask

  // byte-level link model, driven away from the active edge
  initial begin
    lk_done = 1'b0; lk_nack = 1'b0; lk_rbyte = 8'h00;
    forever begin
      @(negedge clk);
      lk_done = 1'b0; lk_nack = 1'b0;
      if (lk_req) begin
        int me;
        logic [1:0] op;
        me = nlog; op = lk_op;
        if (nlog < 64) begin
          log_op[nlog] = lk_op; log_byte[nlog] = lk_wbyte; log_last[nlog] = lk_last;
        end
        nlog++;
        repeat (lk_delay) @(negedge clk);
        lk_done = 1'b1;
        lk_nack = (me == nack_at);
        if (op == 2'd2) begin lk_rbyte = rxq[rxi]; rxi++; end
      end
    end
  end

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    report();
  end

  initial begin
    logic [7:0] d;
    reg_addr = 4'h0; reg_wr = 1'b0; reg_rd = 1'b0; reg_wdata = 8'h00;
    nlog = 0; nack_at = -1; lk_delay = 2; rxi = 0;
    rst = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    reg_read(4'h0, d); chk("R1 status", d, 8'h00);
    reg_read(4'h2, d); chk("R1 control", d, 8'h00);
    reg_read(4'h5, d); chk("R1 data0", d, 8'h00);
    chk("R1 no link request", {31'd0, lk_req}, 0);

    // R2 / R12 register table
    foreach (TBL[i]) begin
      reg_write(TBL[i][19:16], TBL[i][15:8]);
      reg_read(TBL[i][19:16], d);
      chk("R2 readback", {TBL[i][19:16], d}, {TBL[i][19:16], TBL[i][7:0]});
    end
    chk("R12 non-block start no link op", nlog, 0);
    reg_read(4'h0, d); chk("R12 non-block start status", d, 8'h00);
    reg_write(4'h2, 8'h00);

    // R3 block write
    clear_all();
    reg_write(4'h4, 8'hA0);
    reg_write(4'h3, 8'hA5);
    reg_write(4'h5, 8'h03);
    reg_read(4'h2, d);
    reg_write(4'h7, 8'h11); reg_write(4'h7, 8'h22); reg_write(4'h7, 8'h33);
    reg_write(4'h2, 8'h54);
    reg_read(4'h0, d); chk("R3 busy after start", d[0], 1'b1);
    wait_idle();
    chk("R3 op count", nlog, 8);
    log_is("R3 start", 0, 2'd0, 8'h00);
    log_is("R3 addr", 1, 2'd1, 8'hA0);
    log_is("R3 cmd", 2, 2'd1, 8'hA5);
    log_is("R3 count", 3, 2'd1, 8'h03);
    log_is("R3 d0", 4, 2'd1, 8'h11);
    log_is("R3 d1", 5, 2'd1, 8'h22);
    log_is("R3 d2", 6, 2'd1, 8'h33);
    log_is("R3 stop", 7, 2'd3, 8'h00);
    reg_read(4'h0, d); chk("R5 write completion", d, 8'h02);

    // R6 write-one-to-clear
    reg_write(4'h0, 8'h00);
    reg_read(4'h0, d); chk("R6 zero write keeps", d, 8'h02);
    reg_write(4'h0, 8'h02);
    reg_read(4'h0, d); chk("R6 one write clears", d, 8'h00);

    // R4 block read
    clear_all();
    rxq[0] = 8'd4; rxq[1] = 8'hAA; rxq[2] = 8'hBB; rxq[3] = 8'hCC; rxq[4] = 8'hDD;
    reg_write(4'h4, 8'h59);
    reg_write(4'h3, 8'h10);
    reg_write(4'h2, 8'h54);
    wait_idle();
    chk("R4 op count", nlog, 11);
    log_is("R4 start1", 0, 2'd0, 8'h00);
    log_is("R4 addr w", 1, 2'd1, 8'h58);
    log_is("R4 cmd", 2, 2'd1, 8'h10);
    log_is("R4 start2", 3, 2'd0, 8'h00);
    log_is("R4 addr r", 4, 2'd1, 8'h59);
    log_is("R4 recv count", 5, 2'd2, 8'h00);
    chk("R4 count not last", {31'd0, log_last[5]}, 0);
    chk("R4 mid byte not last", {31'd0, log_last[8]}, 0);
    chk("R4 final byte last", {31'd0, log_last[9]}, 1);
    log_is("R4 stop", 10, 2'd3, 8'h00);
    reg_read(4'h0, d); chk("R5 read completion", d, 8'h02);
    reg_read(4'h5, d); chk("R4 data0 count", d, 8'd4);
    reg_read(4'h2, d);
    reg_read(4'h7, d); chk("R4 byte0", d, 8'hAA);
    reg_read(4'h7, d); chk("R4 byte1", d, 8'hBB);
    // R7 control read rewinds index
    reg_read(4'h2, d);
    reg_read(4'h7, d); chk("R7 rewind byte0", d, 8'hAA);
    reg_read(4'h7, d); reg_read(4'h7, d); reg_read(4'h7, d);
    chk("R4 byte3", d, 8'hDD);

    // R8 bad write counts
    clear_all();
    reg_write(4'h4, 8'hA0);
    reg_write(4'h5, 8'h00);
    reg_write(4'h2, 8'h54);
    repeat (10) @(negedge clk);
    reg_read(4'h0, d); chk("R8 count 0 dev err", d, 8'h04);
    chk("R8 count 0 no link", nlog, 0);
    clear_all();
    reg_write(4'h5, 8'd33);
    reg_write(4'h2, 8'h54);
    repeat (10) @(negedge clk);
    reg_read(4'h0, d); chk("R8 count 33 dev err", d, 8'h04);
    chk("R8 count 33 no link", nlog, 0);

    // R9 oversize returned count
    clear_all();
    rxq[0] = 8'd40;
    reg_write(4'h4, 8'h59);
    reg_write(4'h2, 8'h54);
    wait_idle();
    chk("R9 op count", nlog, 7);
    log_is("R9 stop after count", 6, 2'd3, 8'h00);
    reg_read(4'h0, d); chk("R9 dev err", d, 8'h04);
    reg_read(4'h5, d); chk("R9 data0 holds returned", d, 8'd40);

    // R10 nack on address
    clear_all();
    nack_at = 1;
    reg_write(4'h4, 8'hA0);
    reg_write(4'h5, 8'h03);
    reg_write(4'h2, 8'h54);
    wait_idle();
    chk("R10 op count", nlog, 3);
    log_is("R10 stop", 2, 2'd3, 8'h00);
    reg_read(4'h0, d); chk("R10 dev err no done", d, 8'h04);

    // R10 nack on a data byte
    clear_all();
    nack_at = 5;
    reg_write(4'h2, 8'h54);
    wait_idle();
    chk("R10 data nack op count", nlog, 7);
    log_is("R10 data nack stop", 6, 2'd3, 8'h00);
    reg_read(4'h0, d); chk("R10 data nack status", d, 8'h04);

    // R11 kill mid-transfer
    clear_all();
    lk_delay = 8;
    reg_write(4'h2, 8'h54);
    repeat (12) @(negedge clk);
    reg_write(4'h2, 8'h16);
    wait_idle();
    chk("R11 aborted early", {31'd0, nlog < 8}, 1);
    log_is("R11 stop last", nlog - 1, 2'd3, 8'h00);
    reg_read(4'h0, d); chk("R11 failed set", d, 8'h10);
    reg_write(4'h2, 8'h14);
    lk_delay = 2;

    report();
  end

endmodule